// File: doc/BRIEF.md
# Posted/Pending Interrupt Controller with Software Posting

This block gathers interrupt requests from peripheral sources into a vector of posted flags. Each source has one flag. A flag is set when its source fires, and the mask has no say in that. A per-source enable bit (the mask) then decides whether a posted flag becomes pending. Pending flags feed a fixed-priority selector, which drives an interrupt request line and the index of the winning source to the processor. When the processor pulses its acknowledge, the selected flag is cleared.

Software reaches the block through a byte-wide register port. Three status/clear registers hold the posted flags, and software reads them there. Four enable registers follow the status registers. The top bit of the last enable register is a mode switch for software posting. When the switch is off, writing a zero to a status bit clears that flag, and writing a one does nothing. When the switch is on, writing a one raises the flag as if the hardware had fired, and writing a zero does nothing. A parameter marks each source as edge-type (posts on a rising edge) or level-type (posts every cycle the input is high). A second parameter marks unused source positions as reserved.

Top module: `posted_irq_ctrl`

## Requirements
- R1: After reset every posted flag, every enable bit and the mode switch are 0, `irqReq` is 0 and every register reads 0.
- R2: A source event sets its posted flag whatever its enable bit holds. Reading byte address 0xDA+k returns the flags of sources 8k..8k+7 (bit j = source 8k+j, 1 = posted), for k = 0..2.
- R3: An edge-type source posts only in the cycle after its input rises from 0 to 1. A level-type source posts in every cycle its input is 1.
- R4: The enable registers sit at 0xDD+k (k = 0..2, bit j = source 8k+j) and read back their stored value. `irqReq` is 1 exactly when some flag is both posted and enabled.
- R5: The mode switch is bit 7 of address 0xE0. Bits 6..0 of that address read 0.
- R6: With the mode switch at 0, a written 0 in a status register clears that flag and a written 1 leaves it unchanged.
- R7: With the mode switch at 1, a written 1 in a status register posts that flag and a written 0 leaves it unchanged.
- R8: While `irqReq` is 1, `irqIdx` is the lowest-numbered pending source.
- R9: An `irqAck` pulse while `irqReq` is 1 clears only the posted flag of the source named by `irqIdx`. An `irqAck` while `irqReq` is 0 has no effect.
- R10: A hardware event on a source in the same cycle that a write or an acknowledge clears that source leaves the flag posted.
- R11: Reserved source positions always read 0 in both the status and the enable registers. Hardware events, software posting and writes leave them at 0.
- R12: Reads from any address outside 0xDA..0xE0 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 24 | Interrupt source inputs, bit i = source i |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the addressed register (combinational) |
| irqAck | input | 1 | Acknowledge; clears the selected posted flag |
| irqReq | output | 1 | Interrupt request to the processor |
| irqIdx | output | 5 | Index of the highest-priority pending source |

## Verification
The bench builds the block with source positions 0, 7 and 19 reserved and the eight sources of the first status register edge-type, with the rest level-type. Those values bring within reach reserved flags at the edges of a byte and in the middle of one, software posting onto a reserved bit, and both posting kinds under the same clear and acknowledge traffic. Sparse random source activity is mixed with random register writes, including toggles of the mode switch and writes to unmapped addresses, and with random acknowledges. Directed sequences cover an event that collides with a clear, an edge input held high, and the priority order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int CLR_REGS = 3;
  parameter int MSK_REGS = CLR_REGS + 1;
  parameter int SRC_NUM  = CLR_REGS * 8;
  parameter int IDX_W    = $clog2(SRC_NUM);
  parameter int RIDX_W   = $clog2(MSK_REGS);

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_POST = 2'd1,
    RD_MASK = 2'd2,
    RD_CTL  = 2'd3
  } rdKind_t;

  // Strobes passed from the bus decoder to the datapath
  typedef struct packed {
    logic [CLR_REGS-1:0] clrWe;
    logic [CLR_REGS-1:0] mskWe;
    logic                ctlWe;
    logic [7:0]          wrByte;
    logic                ack;
    rdKind_t             rdKind;
    logic [RIDX_W-1:0]   rdReg;
  } icStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter logic [7:0] CLR_BASE = 8'hDA,
  parameter logic [7:0] MSK_BASE = 8'hDD
) (
  input  logic [7:0] busAddr,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  input  logic       irqAck,
  output icStrobe_t  strb
);
  logic [CLR_REGS-1:0] hitClr;
  logic [CLR_REGS-1:0] hitMsk;
  logic                hitCtl;

  genvar k;
  generate
    for (k = 0; k < CLR_REGS; k++) begin : g_dec
      assign hitClr[k] = (busAddr == CLR_BASE + 8'(k));
      assign hitMsk[k] = (busAddr == MSK_BASE + 8'(k));
    end
  endgenerate
  assign hitCtl = (busAddr == MSK_BASE + 8'(CLR_REGS));

  always_comb begin
    strb        = '0;
    strb.wrByte = busWrData;
    strb.ack    = irqAck;
    strb.rdKind = RD_NONE;
    strb.clrWe  = hitClr & {CLR_REGS{busWr}};
    strb.mskWe  = hitMsk & {CLR_REGS{busWr}};
    strb.ctlWe  = hitCtl & busWr;
    for (int i = 0; i < CLR_REGS; i++) begin
      if (hitClr[i]) begin
        strb.rdKind = RD_POST;
        strb.rdReg  = RIDX_W'(i);
      end
      if (hitMsk[i]) begin
        strb.rdKind = RD_MASK;
        strb.rdReg  = RIDX_W'(i);
      end
    end
    if (hitCtl) strb.rdKind = RD_CTL;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter logic [SRC_NUM-1:0] SRC_VALID = '1,
  parameter logic [SRC_NUM-1:0] EDGE_SEL  = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_NUM-1:0] srcIn,
  input  icStrobe_t          strb,
  output logic [7:0]         rdData,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic [SRC_NUM-1:0] postedVec,
  output logic [SRC_NUM-1:0] maskVec,
  output logic               swEn,
  output logic [SRC_NUM-1:0] hwSet
);
  logic [SRC_NUM-1:0] rawSet;
  logic [SRC_NUM-1:0] wrClr;
  logic [SRC_NUM-1:0] swSet;
  logic [SRC_NUM-1:0] ackClr;
  logic [SRC_NUM-1:0] pending;
  logic [SRC_NUM-1:0] postedNext;

  // Per-source event detection: edge-type or level-type
  genvar i;
  generate
    for (i = 0; i < SRC_NUM; i++) begin : g_src
      if (EDGE_SEL[i]) begin : g_edge
        logic prevIn;
        always_ff @(posedge clk) begin
          if (!rstN) prevIn <= 1'b0;
          else       prevIn <= srcIn[i];
        end
        assign rawSet[i] = srcIn[i] & ~prevIn;
      end else begin : g_level
        assign rawSet[i] = srcIn[i];
      end
      assign ackClr[i] = strb.ack && irqReq && (irqIdx == IDX_W'(i));
    end
  endgenerate

  assign hwSet = rawSet & SRC_VALID;

  // Clear-register writes: zeros clear in normal mode, ones post in software mode
  always_comb begin
    wrClr = '0;
    swSet = '0;
    for (int k = 0; k < CLR_REGS; k++) begin
      if (strb.clrWe[k]) begin
        if (swEn) swSet[8*k +: 8] = strb.wrByte;
        else      wrClr[8*k +: 8] = ~strb.wrByte;
      end
    end
  end

  // Set terms are applied last so a same-cycle event is never lost
  assign postedNext = ((postedVec & ~wrClr & ~ackClr) | hwSet | swSet) & SRC_VALID;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postedVec <= '0;
      maskVec   <= '0;
      swEn      <= 1'b0;
    end else begin
      postedVec <= postedNext;
      for (int k = 0; k < CLR_REGS; k++) begin
        if (strb.mskWe[k]) maskVec[8*k +: 8] <= strb.wrByte & SRC_VALID[8*k +: 8];
      end
      if (strb.ctlWe) swEn <= strb.wrByte[7];
    end
  end

  // Fixed priority: lowest index wins
  assign pending = postedVec & maskVec;
  assign irqReq  = |pending;
  always_comb begin
    irqIdx = '0;
    for (int n = SRC_NUM - 1; n >= 0; n--) begin
      if (pending[n]) irqIdx = IDX_W'(n);
    end
  end

  // Read mux
  always_comb begin
    rdData = 8'h00;
    unique case (strb.rdKind)
      RD_POST: begin
        for (int k = 0; k < CLR_REGS; k++)
          if (strb.rdReg == RIDX_W'(k)) rdData = postedVec[8*k +: 8];
      end
      RD_MASK: begin
        for (int k = 0; k < CLR_REGS; k++)
          if (strb.rdReg == RIDX_W'(k)) rdData = maskVec[8*k +: 8];
      end
      RD_CTL:  rdData = {swEn, 7'b0};
      default: rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/posted_irq_ctrl.sv
module posted_irq_ctrl
  import irq_pkg::*;
#(
  parameter logic [7:0]         CLR_BASE  = 8'hDA,
  parameter logic [7:0]         MSK_BASE  = 8'hDD,
  parameter logic [SRC_NUM-1:0] SRC_VALID = '1,
  parameter logic [SRC_NUM-1:0] EDGE_SEL  = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_NUM-1:0] srcIn,
  input  logic [7:0]         busAddr,
  input  logic               busWr,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx
);
  icStrobe_t          strb;
  logic [SRC_NUM-1:0] postedVec;
  logic [SRC_NUM-1:0] maskVec;
  logic               swEn;
  logic [SRC_NUM-1:0] hwSet;

  irq_ctrl #(.CLR_BASE(CLR_BASE), .MSK_BASE(MSK_BASE)) u_ctrl (
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .irqAck    (irqAck),
    .strb      (strb)
  );

  irq_datapath #(.SRC_VALID(SRC_VALID), .EDGE_SEL(EDGE_SEL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strb      (strb),
    .rdData    (busRdData),
    .irqReq    (irqReq),
    .irqIdx    (irqIdx),
    .postedVec (postedVec),
    .maskVec   (maskVec),
    .swEn      (swEn),
    .hwSet     (hwSet)
  );
endmodule

// File: rtl/irq_checker.sv
module irq_checker
  import irq_pkg::*;
#(
  parameter logic [7:0]         CLR_BASE  = 8'hDA,
  parameter logic [SRC_NUM-1:0] SRC_VALID = '1
) (
  input logic               clk,
  input logic               rstN,
  input logic [7:0]         busAddr,
  input logic               busWr,
  input logic [7:0]         busWrData,
  input logic               irqAck,
  input logic               irqReq,
  input logic [IDX_W-1:0]   irqIdx,
  input logic [SRC_NUM-1:0] postedVec,
  input logic [SRC_NUM-1:0] maskVec,
  input logic               swEn,
  input logic [SRC_NUM-1:0] hwSet
);
  logic [SRC_NUM-1:0] pend;
  logic [SRC_NUM-1:0] pendBelow;
  assign pend      = postedVec & maskVec;
  assign pendBelow = pend & ((SRC_NUM'(1) << irqIdx) - SRC_NUM'(1));

  // R2, R10: a hardware event always leaves its flag posted
  a_r2_event_posts: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((postedVec & $past(hwSet)) == $past(hwSet)));

  // R4: request follows pending flags
  a_r4_req_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (|pend));

  // R8: selected index is pending and nothing lower is
  a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendBelow == '0 && pend[irqIdx]));

  // R9: acknowledge clears the selected flag unless an event re-posts it
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && !busWr) |=> (!postedVec[$past(irqIdx)] || $past(hwSet[irqIdx])));

  // R11: reserved positions stay zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((postedVec | maskVec) & ~SRC_VALID) == '0);

  genvar k;
  generate
    for (k = 0; k < CLR_REGS; k++) begin : g_reg
      // R6: zero bits clear in normal mode
      a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
        (busWr && busAddr == CLR_BASE + 8'(k) && !swEn) |=>
        ((postedVec[8*k +: 8] & ~$past(busWrData) & ~$past(hwSet[8*k +: 8])) == 8'h00));
      // R7: one bits post in software mode
      a_r7_one_posts: assert property (@(posedge clk) disable iff (!rstN)
        (busWr && busAddr == CLR_BASE + 8'(k) && swEn) |=>
        ((postedVec[8*k +: 8] & $past(busWrData) & SRC_VALID[8*k +: 8]) ==
         ($past(busWrData) & SRC_VALID[8*k +: 8])));
    end
  endgenerate
endmodule

bind posted_irq_ctrl irq_checker #(.CLR_BASE(CLR_BASE), .SRC_VALID(SRC_VALID)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWrData (busWrData),
  .irqAck    (irqAck),
  .irqReq    (irqReq),
  .irqIdx    (irqIdx),
  .postedVec (postedVec),
  .maskVec   (maskVec),
  .swEn      (swEn),
  .hwSet     (hwSet)
);

// File: tb/sim_posted_irq_ctrl.sv
`timescale 1ns/1ps
module sim_posted_irq_ctrl;
  localparam logic [23:0] VALID = 24'hF7FF7E;
  localparam logic [23:0] EDGES = 24'h0000FF;
  localparam logic [7:0]  CB    = 8'hDA;
  localparam logic [7:0]  MB    = 8'hDD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] srcIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [4:0]  irqIdx;

  always #5 clk = ~clk;

  posted_irq_ctrl #(.CLR_BASE(CB), .MSK_BASE(MB), .SRC_VALID(VALID), .EDGE_SEL(EDGES)) u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .irqAck(irqAck),
    .irqReq(irqReq), .irqIdx(irqIdx)
  );

  // Reference model state
  logic [23:0] mPost = '0, mMask = '0, mPrev = '0;
  logic        mSw = 1'b0;
  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    for (int k = 0; k < 3; k++) begin
      if (a == CB + 8'(k)) return mPost[8*k +: 8];
      if (a == MB + 8'(k)) return mMask[8*k +: 8];
    end
    if (a == MB + 8'd3) return {mSw, 7'b0};
    return 8'h00;
  endfunction

  function automatic string readTag(input logic [7:0] a);
    if (a >= CB && a < CB + 8'd3) return "R2";
    if (a >= MB && a < MB + 8'd3) return "R4";
    if (a == MB + 8'd3) return "R5";
    return "R12";
  endfunction

  function automatic logic [4:0] expIdx();
    logic [23:0] p = mPost & mMask;
    for (int n = 23; n >= 0; n--) if (p[n]) expIdx = 5'(n);
    if (p == '0) expIdx = '0;
  endfunction

  // One clock: drive at negedge, check read, update model, check irq after edge
  task automatic step(input logic [23:0] s, input logic w, input logic [7:0] a,
                      input logic [7:0] d, input logic ak);
    logic [23:0] hw, clr, set, ackc;
    srcIn = s; busWr = w; busAddr = a; busWrData = d; irqAck = ak;
    #1;
    chk(readTag(a), busRdData, expRead(a));
    hw  = ((EDGES & s & ~mPrev) | (~EDGES & s)) & VALID;
    clr = '0; set = '0;
    ackc = (ak && |(mPost & mMask)) ? (24'd1 << expIdx()) : '0;
    if (w) begin
      for (int k = 0; k < 3; k++) if (a == CB + 8'(k)) begin
        if (mSw) set[8*k +: 8] = d; else clr[8*k +: 8] = ~d;
      end
    end
    mPost = ((mPost & ~clr & ~ackc) | hw | set) & VALID;
    if (w) begin
      for (int k = 0; k < 3; k++) if (a == MB + 8'(k)) mMask[8*k +: 8] = d & VALID[8*k +: 8];
      if (a == MB + 8'd3) mSw = d[7];
    end
    mPrev = s;
    @(posedge clk);
    @(negedge clk);
    chk("R4", {31'b0, irqReq}, {31'b0, |(mPost & mMask)});
    if (|(mPost & mMask)) chk("R8", {27'b0, irqIdx}, {27'b0, expIdx()});
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] e, input string tag);
    busWr = 1'b0; busAddr = a; irqAck = 1'b0;
    #1;
    chk(tag, busRdData, e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", {31'b0, irqReq}, 32'd0);
    for (int a = 0; a < 7; a++) peek(CB + 8'(a), 8'h00, "R1");
    // R2: masked level source 9 still posts
    step(24'h000200, 0, 8'h00, 8'h00, 0);
    step(24'h000000, 0, 8'h00, 8'h00, 0);
    peek(CB + 8'd1, 8'h02, "R2");
    chk("R2", {31'b0, irqReq}, 32'd0);
    // R4: enable it
    step(24'h0, 1, MB + 8'd1, 8'h02, 0);
    chk("R4", {31'b0, irqReq}, 32'd1);
    chk("R8", {27'b0, irqIdx}, 32'd9);
    // R3: edge source 1 held high posts once
    step(24'h000002, 0, 8'h00, 8'h00, 0);
    step(24'h000002, 1, CB, 8'hFF, 0);
    peek(CB, 8'h02, "R6");
    step(24'h000002, 1, CB, 8'hFD, 0);
    step(24'h000002, 0, 8'h00, 8'h00, 0);
    peek(CB, 8'h00, "R3");
    // R3: level source 10 held high reposts after clear
    step(24'h000400, 0, 8'h00, 8'h00, 0);
    step(24'h000400, 1, CB + 8'd1, 8'hFB, 0);
    peek(CB + 8'd1, 8'h06, "R10");
    step(24'h000000, 1, CB + 8'd1, 8'h00, 0);
    peek(CB + 8'd1, 8'h00, "R6");
    // R5/R7/R11: software posting incl. reserved bit 19
    step(24'h0, 1, MB + 8'd3, 8'hFF, 0);
    peek(MB + 8'd3, 8'h80, "R5");
    step(24'h0, 1, CB + 8'd2, 8'h0F, 0);
    peek(CB + 8'd2, 8'h07, "R7");
    step(24'h0, 1, CB + 8'd2, 8'h00, 0);
    peek(CB + 8'd2, 8'h07, "R7");
    step(24'h0, 1, MB, 8'hFF, 0);
    peek(MB, 8'h7E, "R11");
    step(24'h0, 1, CB, 8'hFF, 0);
    peek(CB, 8'h7E, "R11");
    // R8/R9: enable all, ack the lowest, ack when idle
    step(24'h0, 1, MB + 8'd2, 8'hFF, 0);
    chk("R8", {27'b0, irqIdx}, 32'd1);
    step(24'h0, 0, 8'h00, 8'h00, 1);
    peek(CB, 8'h7C, "R9");
    // R12: unmapped write
    step(24'h0, 1, 8'h10, 8'hFF, 0);
    peek(8'h10, 8'h00, "R12");
    // Random phase
    for (int n = 0; n < 5000; n++) begin
      logic [23:0] s;
      logic [7:0]  a;
      s = 24'($urandom & $urandom & $urandom & $urandom);
      a = ($urandom % 10 == 0) ? 8'($urandom) : CB + 8'($urandom % 8);
      step(s, ($urandom % 3) == 0, a, 8'($urandom), ($urandom % 4) == 0);
    end
    // R1: reset mid-run clears everything
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    mPost = '0; mMask = '0; mPrev = '0; mSw = 1'b0;
    chk("R1", {31'b0, irqReq}, 32'd0);
    peek(MB + 8'd3, 8'h00, "R1");
    done = 1;
    summary();
  end
endmodule